// File: doc/BRIEF.md
# Core Clock Frequency Change Sequencer

This block runs the hardware side of a software-requested change of the core PLL frequency. Software writes the clock configuration with a start bit set, a new PLL ratio and, if wanted, the turbo bit. From then on the sequencer stops the CPU clock and asks the memory controller to drain its outstanding work. It then has SDRAM put into self-refresh and programs the new ratio into the PLL. A cycle counter stands in for the PLL lock time. When the count runs out, the sequencer brings SDRAM out of self-refresh and turns the CPU clock back on.

While the sequence runs, the block withholds events from the core. Interrupt requests are latched and delivered when the sequence ends. DMA requests, supply-fault and battery-fault inputs, and imprecise data aborts are masked for the whole sequence. Because the fault inputs are masked, sleep entry cannot begin partway through a change.

Resets are handled by type. A watchdog reset aborts the sequence at once and puts the PLL back to its reset ratio, and so does the hardware reset (`rst_n`, asynchronous). A GPIO reset lets the relock finish at the new ratio and holds its own reset exit until then. The fixed-frequency peripheral clocks are not controlled here and keep running. There are no streaming data paths: every pin is plain control or status.

Top module: `clkchg_seq`

## Requirements
- R1: While `rst_n` is low and right after it is released: `cpu_clk_en`=1, `seq_busy`=0, `pll_ratio`=RESET_RATIO (default 1), `turbo_en`=0, and `mem_drain_req`, `mem_sr_req` and `rst_exit_hold` are 0.
- R2: A write while idle with `cfg_start`=1 makes `seq_busy`=1, `cpu_clk_en`=0 and `mem_drain_req`=1 from the next cycle. A write with `cfg_start`=0 changes only `turbo_en`, on the next cycle, and stores the ratio for a later sequence.
- R3: `mem_sr_req` rises only in the cycle after `mem_idle` is seen high during the drain. `mem_drain_req` falls in that same cycle.
- R4: `pll_ratio` takes the ratio from the start write in the cycle after `mem_sr_ack` is seen high. `mem_sr_req` then stays high for `lock_cycles`+1 cycles (counting from that cycle) before it falls.
- R5: After `mem_sr_req` falls, `cpu_clk_en` returns to 1 and `seq_busy` to 0 only in the cycle after `mem_sr_ack` is seen low. The turbo bit from the start write appears on `turbo_en` in that same cycle.
- R6: While the sequence runs, `irq_out` is 0 and each `irq_in` bit that is seen high is latched. In the first idle cycle `irq_out` shows the latched bits ORed with the live inputs; after that it follows `irq_in`.
- R7: `dma_req_out`, `vfault_out`, `bfault_out` and `dabort_out` are 0 while the sequence runs and follow their inputs when idle.
- R8: A `wdt_rst` pulse aborts any sequence. In the next cycle the block is idle, `cpu_clk_en`=1, `mem_sr_req`=0, `pll_ratio`=RESET_RATIO, `turbo_en`=0, and any latched interrupts are discarded.
- R9: A `gpio_rst` pulse during a sequence sets `rst_exit_hold` from the next cycle until the cycle the sequence ends, and the sequence still finishes at the new ratio. A `gpio_rst` pulse while idle has no effect.
- R10: Configuration writes made while the sequence runs are ignored and do not change the ratio or the turbo value that the sequence applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the lock-count reference |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog reset request, one-cycle pulse |
| gpio_rst | input | 1 | GPIO reset request, one-cycle pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_start | input | 1 | Start bit of the write |
| cfg_turbo | input | 1 | Turbo bit of the write |
| cfg_ratio | input | RATIO_W | Requested PLL ratio |
| lock_cycles | input | CNT_W | PLL lock wait, in cycles |
| mem_idle | input | 1 | Memory controller has drained |
| mem_sr_ack | input | 1 | SDRAM is in self-refresh |
| irq_in | input | IRQ_W | Raw interrupt requests |
| dma_req_in | input | 1 | Raw DMA request |
| vfault_in | input | 1 | Supply fault |
| bfault_in | input | 1 | Battery fault |
| dabort_in | input | 1 | Imprecise data abort |
| cpu_clk_en | output | 1 | CPU clock enable |
| seq_busy | output | 1 | Start-bit readback; clears itself on exit |
| mem_drain_req | output | 1 | Request to drain memory traffic |
| mem_sr_req | output | 1 | Request to hold SDRAM in self-refresh |
| pll_ratio | output | RATIO_W | Ratio driven to the PLL |
| turbo_en | output | 1 | Turbo mode |
| rst_exit_hold | output | 1 | Delays GPIO reset exit |
| irq_out | output | IRQ_W | Gated interrupts to the core |
| dma_req_out | output | 1 | Gated DMA request |
| vfault_out | output | 1 | Gated supply fault |
| bfault_out | output | 1 | Gated battery fault |
| dabort_out | output | 1 | Gated data abort |

## Verification
Every state change happens at the first clock edge after the input that causes it. The bench drives inputs at the falling edge and checks outputs at the next falling edge, so a registered result is due one sample later. The gated event outputs are combinational and are checked at the same sample as their inputs. For the lock wait, the bench counts falling-edge samples starting from the `mem_sr_ack` edge and expects `mem_sr_req` to first read low at sample `lock_cycles`+2. A monitor compares the final ratio and turbo value with the queued expectation in the sample where `seq_busy` falls, whether the sequence completes or is aborted.

// File: rtl/clkchg_pkg.sv
package clkchg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_SELFREF = 3'd2,
    ST_RELOCK  = 3'd3,
    ST_SREXIT  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/clkchg_lock_timer.sv
module clkchg_lock_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= ZERO;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != ZERO) cnt_q <= cnt_q - ONE;
  end

  assign done = (cnt_q == ZERO);
endmodule

// File: rtl/clkchg_evt_gate.sv
module clkchg_evt_gate #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             block,
  input  logic [IRQ_W-1:0] irq_in,
  input  logic             dma_in,
  input  logic             vflt_in,
  input  logic             bflt_in,
  input  logic             dabt_in,
  output logic [IRQ_W-1:0] irq_out,
  output logic             dma_out,
  output logic             vflt_out,
  output logic             bflt_out,
  output logic             dabt_out
);
  logic [IRQ_W-1:0] held_q;

  // held interrupts live until the first idle cycle has shown them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= '0;
    else if (clr)   held_q <= '0;
    else if (block) held_q <= held_q | irq_in;
    else            held_q <= '0;
  end

  assign irq_out  = block ? '0 : (irq_in | held_q);
  assign dma_out  = dma_in  & ~block;
  assign vflt_out = vflt_in & ~block;
  assign bflt_out = bflt_in & ~block;
  assign dabt_out = dabt_in & ~block;
endmodule

// File: rtl/clkchg_fsm.sv
module clkchg_fsm
  import clkchg_pkg::*;
#(
  parameter int               RATIO_W     = 5,
  parameter logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_rst,
  input  logic               gpio_rst,
  input  logic               cfg_wr,
  input  logic               cfg_start,
  input  logic               cfg_turbo,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               mem_idle,
  input  logic               mem_sr_ack,
  input  logic               lock_done,
  output logic               lock_load,
  output logic               lock_run,
  output logic               busy,
  output logic               cpu_clk_en,
  output logic               mem_drain_req,
  output logic               mem_sr_req,
  output logic [RATIO_W-1:0] pll_ratio,
  output logic               turbo_en,
  output logic               rst_exit_hold
);
  seq_state_t         state_q, state_nx;
  logic [RATIO_W-1:0] stage_ratio_q;
  logic               stage_turbo_q;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE:    if (cfg_wr && cfg_start) state_nx = ST_DRAIN;
      ST_DRAIN:   if (mem_idle)            state_nx = ST_SELFREF;
      ST_SELFREF: if (mem_sr_ack)          state_nx = ST_RELOCK;
      ST_RELOCK:  if (lock_done)           state_nx = ST_SREXIT;
      ST_SREXIT:  if (!mem_sr_ack)         state_nx = ST_IDLE;
      default:                             state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      pll_ratio     <= RESET_RATIO;
      turbo_en      <= 1'b0;
      stage_ratio_q <= RESET_RATIO;
      stage_turbo_q <= 1'b0;
      rst_exit_hold <= 1'b0;
    end else if (wdt_rst) begin
      state_q       <= ST_IDLE;
      pll_ratio     <= RESET_RATIO;
      turbo_en      <= 1'b0;
      stage_ratio_q <= RESET_RATIO;
      stage_turbo_q <= 1'b0;
      rst_exit_hold <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (state_q == ST_IDLE && cfg_wr) begin
        stage_ratio_q <= cfg_ratio;
        if (cfg_start) stage_turbo_q <= cfg_turbo;
        else           turbo_en      <= cfg_turbo;
      end
      if (state_q == ST_SELFREF && mem_sr_ack) pll_ratio <= stage_ratio_q;
      if (state_q == ST_SREXIT && !mem_sr_ack) turbo_en  <= stage_turbo_q;
      if (state_nx == ST_IDLE)                 rst_exit_hold <= 1'b0;
      else if (gpio_rst && state_q != ST_IDLE) rst_exit_hold <= 1'b1;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign cpu_clk_en    = (state_q == ST_IDLE);
  assign mem_drain_req = (state_q == ST_DRAIN);
  assign mem_sr_req    = (state_q == ST_SELFREF) || (state_q == ST_RELOCK);
  assign lock_load     = (state_q == ST_SELFREF) && mem_sr_ack;
  assign lock_run      = (state_q == ST_RELOCK);
endmodule

// File: rtl/clkchg_seq.sv
module clkchg_seq #(
  parameter int                 RATIO_W     = 5,
  parameter int                 CNT_W       = 12,
  parameter int                 IRQ_W       = 4,
  parameter logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_rst,
  input  logic               gpio_rst,
  input  logic               cfg_wr,
  input  logic               cfg_start,
  input  logic               cfg_turbo,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [CNT_W-1:0]   lock_cycles,
  input  logic               mem_idle,
  input  logic               mem_sr_ack,
  input  logic [IRQ_W-1:0]   irq_in,
  input  logic               dma_req_in,
  input  logic               vfault_in,
  input  logic               bfault_in,
  input  logic               dabort_in,
  output logic               cpu_clk_en,
  output logic               seq_busy,
  output logic               mem_drain_req,
  output logic               mem_sr_req,
  output logic [RATIO_W-1:0] pll_ratio,
  output logic               turbo_en,
  output logic               rst_exit_hold,
  output logic [IRQ_W-1:0]   irq_out,
  output logic               dma_req_out,
  output logic               vfault_out,
  output logic               bfault_out,
  output logic               dabort_out
);
  logic lock_load, lock_run, lock_done;

  clkchg_fsm #(.RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
    .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_turbo(cfg_turbo),
    .cfg_ratio(cfg_ratio), .mem_idle(mem_idle), .mem_sr_ack(mem_sr_ack),
    .lock_done(lock_done), .lock_load(lock_load), .lock_run(lock_run),
    .busy(seq_busy), .cpu_clk_en(cpu_clk_en), .mem_drain_req(mem_drain_req),
    .mem_sr_req(mem_sr_req), .pll_ratio(pll_ratio), .turbo_en(turbo_en),
    .rst_exit_hold(rst_exit_hold)
  );

  clkchg_lock_timer #(.CNT_W(CNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(lock_load), .load_val(lock_cycles),
    .run(lock_run), .done(lock_done)
  );

  clkchg_evt_gate #(.IRQ_W(IRQ_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .clr(wdt_rst), .block(seq_busy),
    .irq_in(irq_in), .dma_in(dma_req_in), .vflt_in(vfault_in),
    .bflt_in(bfault_in), .dabt_in(dabort_in), .irq_out(irq_out),
    .dma_out(dma_req_out), .vflt_out(vfault_out), .bflt_out(bfault_out),
    .dabt_out(dabort_out)
  );
endmodule

// File: rtl/clkchg_seq_chk.sv
module clkchg_seq_chk #(
  parameter int                 RATIO_W     = 5,
  parameter int                 IRQ_W       = 4,
  parameter logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wdt_rst,
  input logic               mem_idle,
  input logic               mem_sr_ack,
  input logic               cpu_clk_en,
  input logic               mem_drain_req,
  input logic               mem_sr_req,
  input logic [RATIO_W-1:0] pll_ratio,
  input logic               rst_exit_hold,
  input logic [IRQ_W-1:0]   irq_out,
  input logic               dma_req_out,
  input logic               vfault_out,
  input logic               bfault_out,
  input logic               dabort_out
);
  assert_sr_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sr_req) |-> ($past(mem_idle) && $past(mem_drain_req)));

  assert_ratio_in_selfref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_ratio) |-> ($past(mem_sr_ack) || $past(wdt_rst)));

  assert_clk_after_srexit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> (!$past(mem_sr_ack) || $past(wdt_rst)));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> (irq_out == '0));

  assert_events_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> !(dma_req_out || vfault_out || bfault_out || dabort_out));

  assert_wdt_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (cpu_clk_en && !mem_sr_req && pll_ratio == RESET_RATIO));

  assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_exit_hold |-> !cpu_clk_en);
endmodule

bind clkchg_seq clkchg_seq_chk #(.RATIO_W(RATIO_W), .IRQ_W(IRQ_W),
  .RESET_RATIO(RESET_RATIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .mem_idle(mem_idle),
  .mem_sr_ack(mem_sr_ack), .cpu_clk_en(cpu_clk_en),
  .mem_drain_req(mem_drain_req), .mem_sr_req(mem_sr_req),
  .pll_ratio(pll_ratio), .rst_exit_hold(rst_exit_hold), .irq_out(irq_out),
  .dma_req_out(dma_req_out), .vfault_out(vfault_out),
  .bfault_out(bfault_out), .dabort_out(dabort_out)
);

// File: tb/clkchg_seq_bench.sv
module clkchg_seq_bench;
  localparam int RATIO_W = 5;
  localparam int CNT_W   = 12;
  localparam int IRQ_W   = 4;
  localparam logic [RATIO_W-1:0] RST_RATIO = 5'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_rst = 0, gpio_rst = 0, cfg_wr = 0, cfg_start = 0, cfg_turbo = 0;
  logic [RATIO_W-1:0] cfg_ratio = '0;
  logic [CNT_W-1:0]   lock_cycles = '0;
  logic mem_idle = 0, mem_sr_ack = 0;
  logic [IRQ_W-1:0] irq_in = '0;
  logic dma_req_in = 0, vfault_in = 0, bfault_in = 0, dabort_in = 0;
  logic cpu_clk_en, seq_busy, mem_drain_req, mem_sr_req, turbo_en, rst_exit_hold;
  logic [RATIO_W-1:0] pll_ratio;
  logic [IRQ_W-1:0] irq_out;
  logic dma_req_out, vfault_out, bfault_out, dabort_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  clkchg_seq u_clkchg_seq (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
    .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_turbo(cfg_turbo),
    .cfg_ratio(cfg_ratio), .lock_cycles(lock_cycles), .mem_idle(mem_idle),
    .mem_sr_ack(mem_sr_ack), .irq_in(irq_in), .dma_req_in(dma_req_in),
    .vfault_in(vfault_in), .bfault_in(bfault_in), .dabort_in(dabort_in),
    .cpu_clk_en(cpu_clk_en), .seq_busy(seq_busy), .mem_drain_req(mem_drain_req),
    .mem_sr_req(mem_sr_req), .pll_ratio(pll_ratio), .turbo_en(turbo_en),
    .rst_exit_hold(rst_exit_hold), .irq_out(irq_out), .dma_req_out(dma_req_out),
    .vfault_out(vfault_out), .bfault_out(bfault_out), .dabort_out(dabort_out)
  );

  typedef struct {
    logic [RATIO_W-1:0] ratio;
    logic               turbo;
    string              req;
  } exit_item_t;
  exit_item_t exp_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_exit(logic [RATIO_W-1:0] r, logic t, string req);
    exit_item_t it;
    it.ratio = r; it.turbo = t; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: compares the queued final state in the sample where seq_busy falls
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_busy && !seq_busy) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected exit", 32'(seq_busy), 32'(1));
      end else begin
        exit_item_t it;
        it = exp_q.pop_front();
        chk({it.req, " exit ratio"}, 32'(pll_ratio), 32'(it.ratio));
        chk({it.req, " exit turbo"}, 32'(turbo_en), 32'(it.turbo));
        chk({it.req, " exit clk"}, 32'(cpu_clk_en), 32'(1));
      end
    end
    prev_busy <= seq_busy;
  end

  task automatic start_seq(logic [RATIO_W-1:0] r, logic t);
    @(negedge clk);
    cfg_wr = 1; cfg_start = 1; cfg_ratio = r; cfg_turbo = t;
    @(negedge clk);
    cfg_wr = 0; cfg_start = 0;
    chk("R2 busy", 32'(seq_busy), 32'(1));
    chk("R2 clk off", 32'(cpu_clk_en), 32'(0));
    chk("R2 drain", 32'(mem_drain_req), 32'(1));
  endtask

  // full sequence; evts adds gated events and an ignored write, gpio pulses a GPIO reset
  task automatic run_seq(logic [RATIO_W-1:0] r, logic t, int lk, bit evts, bit gpio);
    lock_cycles = CNT_W'(lk);
    push_exit(r, t, "R4/R5");
    start_seq(r, t);
    if (evts) begin
      irq_in = 4'b0101; dma_req_in = 1; vfault_in = 1; bfault_in = 1; dabort_in = 1;
      cfg_wr = 1; cfg_start = 1; cfg_ratio = 5'd30; cfg_turbo = ~t;   // R10 ignored
      #1;
      chk("R6 irq gated", 32'(irq_out), 32'(0));
      chk("R7 dma gated", 32'(dma_req_out), 32'(0));
      chk("R7 faults gated", 32'({vfault_out, bfault_out, dabort_out}), 32'(0));
      @(negedge clk);
      irq_in = '0; dma_req_in = 0; vfault_in = 0; bfault_in = 0; dabort_in = 0;
      cfg_wr = 0; cfg_start = 0;
    end
    @(negedge clk);
    chk("R3 no sr before idle", 32'(mem_sr_req), 32'(0));
    mem_idle = 1;
    @(negedge clk);
    mem_idle = 0;
    chk("R3 sr req", 32'(mem_sr_req), 32'(1));
    chk("R3 drain dropped", 32'(mem_drain_req), 32'(0));
    mem_sr_ack = 1;
    @(negedge clk);
    chk("R4 ratio applied", 32'(pll_ratio), 32'(r));
    begin
      int k = 1;
      while (mem_sr_req && k < 200) begin
        if (gpio && k == 1) gpio_rst = 1;
        @(negedge clk);
        gpio_rst = 0;
        k++;
        if (gpio && k == 2) chk("R9 hold set", 32'(rst_exit_hold), 32'(1));
      end
      chk("R4 lock length", 32'(k), 32'(lk + 2));
    end
    chk("R5 clk still off", 32'(cpu_clk_en), 32'(0));
    if (gpio) chk("R9 hold until exit", 32'(rst_exit_hold), 32'(1));
    mem_sr_ack = 0;
    @(negedge clk);
    chk("R5 busy clear", 32'(seq_busy), 32'(0));
    chk("R9 hold released", 32'(rst_exit_hold), 32'(0));
    if (evts) begin
      chk("R6 held irq delivered", 32'(irq_out), 32'(4'b0101));
      @(negedge clk);
      chk("R6 held irq cleared", 32'(irq_out), 32'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 clk en", 32'(cpu_clk_en), 32'(1));
    chk("R1 ratio", 32'(pll_ratio), 32'(RST_RATIO));
    chk("R1 outs", 32'({seq_busy, turbo_en, mem_drain_req, mem_sr_req, rst_exit_hold}), 32'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 32'({seq_busy, mem_sr_req, turbo_en}), 32'(0));

    // R7 pass-through when idle
    dma_req_in = 1; vfault_in = 1; irq_in = 4'b0010;
    #1;
    chk("R7 dma pass", 32'(dma_req_out), 32'(1));
    chk("R7 fault pass", 32'(vfault_out), 32'(1));
    chk("R6 irq pass", 32'(irq_out), 32'(4'b0010));
    @(negedge clk);
    dma_req_in = 0; vfault_in = 0; irq_in = '0;

    // R2 write without start: turbo only
    cfg_wr = 1; cfg_start = 0; cfg_turbo = 1; cfg_ratio = 5'd9;
    @(negedge clk);
    cfg_wr = 0;
    chk("R2 turbo immediate", 32'(turbo_en), 32'(1));
    chk("R2 no start", 32'(seq_busy), 32'(0));
    chk("R2 ratio unchanged", 32'(pll_ratio), 32'(RST_RATIO));

    // R9 GPIO reset while idle
    gpio_rst = 1;
    @(negedge clk);
    gpio_rst = 0;
    chk("R9 idle gpio ignored", 32'({rst_exit_hold, seq_busy}), 32'(0));

    run_seq(5'd12, 1'b0, 3, 1'b1, 1'b0);
    run_seq(5'd7,  1'b1, 0, 1'b0, 1'b0);
    run_seq(5'd20, 1'b0, 5, 1'b0, 1'b1);

    // R8 abort during drain
    lock_cycles = 12'd4;
    push_exit(RST_RATIO, 1'b0, "R8 drain abort");
    start_seq(5'd15, 1'b1);
    irq_in = 4'b1000;
    @(negedge clk);
    irq_in = '0;
    wdt_rst = 1;
    @(negedge clk);
    wdt_rst = 0;
    chk("R8 sr low", 32'(mem_sr_req), 32'(0));
    chk("R8 held irq dropped", 32'(irq_out), 32'(0));

    // R8 abort during relock
    push_exit(RST_RATIO, 1'b0, "R8 relock abort");
    start_seq(5'd17, 1'b1);
    mem_idle = 1;
    @(negedge clk);
    mem_idle = 0; mem_sr_ack = 1;
    @(negedge clk);
    chk("R4 ratio before abort", 32'(pll_ratio), 32'(17));
    wdt_rst = 1;
    @(negedge clk);
    wdt_rst = 0; mem_sr_ack = 0;
    chk("R8 ratio reset", 32'(pll_ratio), 32'(RST_RATIO));
    chk("R8 idle", 32'(seq_busy), 32'(0));
    repeat (2) @(negedge clk);
    chk("R5 queue drained", 32'(exp_q.size()), 32'(0));
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule